// File: doc/BRIEF.md
# Streaming Eight-Point Fixed-Point Inverse DCT

This block is a small transform coprocessor that hangs off two point-to-point streams, one towards it and one away from it. Each stream uses a data word, a valid flag and a ready flag, and a word moves in any cycle where valid and ready are both high. A software or hardware producer pushes eight frequency-domain samples, lowest index first. The block then evaluates the one-dimensional eight-point inverse DCT for all eight outputs at once, using a parallel array of constant multipliers. It returns the eight spatial-domain results on the output stream in index order.

The cosine weights are fixed-point constants built into the block. The full-precision sum for each output is rounded once and then clamped to the sample range. While a transform is in flight the block refuses new input, so a single transform owns the block from its first accepted word to its last delivered result. Backpressure on the output side stalls delivery without losing or reordering anything.

Top module: `idct8_stream`

## Requirements
- R1: A word is taken when in_valid and in_ready are both high at a rising clock edge. Bits SMP_W-1:0 carry a two's-complement sample and the bits above them are ignored. The first word taken after reset or after a finished transform is coefficient X[0], the next X[1], and so on up to X[7].
- R2: From the clock edge that takes the eighth word, in_ready stays low until the edge that delivers the eighth result. It is high again in the cycle after that edge.
- R3: Result n is floor((S + 2^13) / 2^14), where S = sum over k of C[n][k]*X[k] and C[n][k] = round(2^13 * a(k) * cos((2n+1)*k*pi/16)). Here a(0) = 1/sqrt(2), a(k) = 1 for k > 0, and round() goes to the nearest integer with halves away from zero.
- R4: A rounded result above 32767 is delivered as 32767, and one below -32768 is delivered as -32768.
- R5: In every output word, bits SMP_W-1:0 hold the result and every bit above them equals bit SMP_W-1.
- R6: Exactly eight results are delivered per transform, in the order n = 0, 1, ..., 7. After the eighth one, out_valid is low.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data does not change on the next cycle.
- R8: While rst is high and in the first cycle after it falls, in_ready is high and out_valid is low. Reset discards a partly gathered set of input words.
- R9: For inputs whose magnitudes are all at most 1024, every result is within 1 of the real-valued inverse DCT sum over k of (a(k)/2)*X[k]*cos((2n+1)*k*pi/16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers a word on in_data |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | BUS_W | Input word; the low SMP_W bits are the sample |
| out_valid | output | 1 | A result word is on out_data |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | BUS_W | Sign-extended result word |

## Verification
The bench builds the block with its defaults: a 32-bit stream word carrying a 16-bit sample. This leaves sixteen upper bits free. The bench fills them with junk on input to show they are ignored, and checks them for sign copies on output. Because the sample is the full 16 bits, the bench can drive inputs at full scale. All-maximum and all-minimum inputs push the first result well past the clamp limits in both directions. Small-amplitude vectors bring the real-valued tolerance check within reach.

// File: rtl/idct_pkg.sv
package idct_pkg;

  // Transform size and coefficient format are fixed by the cosine set below.
  localparam int NPTS   = 8;
  localparam int COEF_W = 16;
  localparam int FRAC   = 14;

  // Half-scaled cosine magnitude: round(2^13 * cos(j*pi/16)), j = 0..8.
  function automatic logic signed [COEF_W-1:0] cos_q(input int j);
    case (j)
      0:       return 16'sd8192;
      1:       return 16'sd8035;
      2:       return 16'sd7568;
      3:       return 16'sd6811;
      4:       return 16'sd5793;
      5:       return 16'sd4551;
      6:       return 16'sd3135;
      7:       return 16'sd1598;
      default: return 16'sd0;
    endcase
  endfunction

  // Weight for output n, input k, folded onto the first quadrant.
  function automatic logic signed [COEF_W-1:0] weight(input int n, input int k);
    int m;
    if (k == 0) return 16'sd5793;
    m = ((2 * n + 1) * k) % 32;
    if (m <= 8)       return cos_q(m);
    else if (m <= 16) return -cos_q(16 - m);
    else if (m <= 24) return -cos_q(m - 16);
    else              return cos_q(32 - m);
  endfunction

endpackage

// File: rtl/idct_gather.sv
module idct_gather
  import idct_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int SMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [BUS_W-1:0]        in_data,
  input  logic                    release_i,
  output logic                    in_ready,
  output logic                    in_fire,
  output logic                    full_o,
  output logic signed [SMP_W-1:0] smp_o [NPTS]
);

  localparam int CNT_W = $clog2(NPTS);

  logic [CNT_W-1:0] wr_idx;
  logic             full_q;

  assign in_ready = !full_q;
  assign in_fire  = in_valid && in_ready;
  assign full_o   = full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      full_q <= 1'b0;
    end else begin
      if (in_fire) begin
        if (wr_idx == CNT_W'(NPTS - 1)) begin
          wr_idx <= '0;
          full_q <= 1'b1;
        end else begin
          wr_idx <= wr_idx + 1'b1;
        end
      end
      if (release_i) full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (in_fire) smp_o[wr_idx] <= in_data[SMP_W-1:0];
  end

endmodule

// File: rtl/idct_core.sv
module idct_core
  import idct_pkg::*;
#(
  parameter int SMP_W = 16
) (
  input  logic signed [SMP_W-1:0] smp_i [NPTS],
  output logic signed [SMP_W-1:0] res_o [NPTS]
);

  localparam int ACC_W = SMP_W + COEF_W + $clog2(NPTS);
  localparam logic signed [ACC_W-1:0] RND_HALF = ACC_W'(2 ** (FRAC - 1));
  localparam logic signed [ACC_W-1:0] SAT_HI   = ACC_W'(2 ** (SMP_W - 1) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO   = ACC_W'(-(2 ** (SMP_W - 1)));

  // Round the full-precision sum once, then clamp to the sample range.
  function automatic logic signed [SMP_W-1:0] rnd_sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] r;
    r = (a + RND_HALF) >>> FRAC;
    if (r > SAT_HI)      return SAT_HI[SMP_W-1:0];
    else if (r < SAT_LO) return SAT_LO[SMP_W-1:0];
    else                 return r[SMP_W-1:0];
  endfunction

  for (genvar n = 0; n < NPTS; n++) begin : g_out
    logic signed [ACC_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int k = 0; k < NPTS; k++)
        acc = acc + ACC_W'(weight(n, k)) * ACC_W'(smp_i[k]);
    end
    assign res_o[n] = rnd_sat(acc);
  end

endmodule

// File: rtl/idct_drain.sv
module idct_drain
  import idct_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int SMP_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load_i,
  input  logic signed [SMP_W-1:0] res_i [NPTS],
  input  logic                    out_ready,
  output logic                    out_valid,
  output logic [BUS_W-1:0]        out_data,
  output logic                    out_fire,
  output logic                    last_fire
);

  localparam int CNT_W = $clog2(NPTS);
  localparam int EXT_W = BUS_W - SMP_W;

  logic signed [SMP_W-1:0] bank [NPTS];
  logic [CNT_W-1:0]        rd_idx;
  logic                    busy_q;
  logic signed [SMP_W-1:0] cur;

  assign out_valid = busy_q;
  assign out_fire  = busy_q && out_ready;
  assign last_fire = out_fire && (rd_idx == CNT_W'(NPTS - 1));
  assign cur       = bank[rd_idx];
  assign out_data  = {{EXT_W{cur[SMP_W-1]}}, cur};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      rd_idx <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      rd_idx <= '0;
    end else if (out_fire) begin
      rd_idx <= last_fire ? '0 : rd_idx + 1'b1;
      if (last_fire) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load_i) bank <= res_i;
  end

endmodule

// File: rtl/idct8_stream.sv
module idct8_stream
  import idct_pkg::*;
#(
  parameter int BUS_W = 32,
  parameter int SMP_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BUS_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [BUS_W-1:0] out_data
);

  // Named internal events, visible to the bound checker.
  logic in_fire;
  logic blk_full;
  logic load_fire;
  logic out_fire;
  logic last_fire;

  logic signed [SMP_W-1:0] smp [NPTS];
  logic signed [SMP_W-1:0] res [NPTS];

  assign load_fire = blk_full && !out_valid;

  idct_gather #(.BUS_W(BUS_W), .SMP_W(SMP_W)) u_gather (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .release_i (last_fire),
    .in_ready  (in_ready),
    .in_fire   (in_fire),
    .full_o    (blk_full),
    .smp_o     (smp)
  );

  idct_core #(.SMP_W(SMP_W)) u_core (
    .smp_i (smp),
    .res_o (res)
  );

  idct_drain #(.BUS_W(BUS_W), .SMP_W(SMP_W)) u_drain (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_fire),
    .res_i     (res),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_fire  (out_fire),
    .last_fire (last_fire)
  );

endmodule

// File: rtl/idct8_stream_chk.sv
module idct8_stream_chk #(
  parameter int BUS_W = 32,
  parameter int SMP_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_fire,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [BUS_W-1:0] out_data
);

  logic [2:0] icnt;
  logic [2:0] ocnt;
  logic       ofire;

  assign ofire = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      icnt <= '0;
      ocnt <= '0;
    end else begin
      if (in_fire) icnt <= icnt + 1'b1;
      if (ofire)   ocnt <= ocnt + 1'b1;
    end
  end

  // R2: the eighth accepted word closes the input side.
  p_stall_after_eighth_r2: assert property (@(posedge clk) disable iff (rst)
    (in_fire && icnt == 3'd7) |=> !in_ready);

  // R2: no input is taken while results are being delivered.
  p_closed_during_emit_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R2: input reopens only right after the eighth result leaves.
  p_reopen_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ready) |-> $past(ofire && ocnt == 3'd7));

  // R5: upper bits copy the result sign.
  p_sign_ext_r5: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data[BUS_W-1:SMP_W] == {(BUS_W-SMP_W){out_data[SMP_W-1]}});

  // R6: out_valid drops only after the eighth delivery.
  p_eight_out_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> $past(ofire && ocnt == 3'd7));

  // R7: a stalled result is held.
  p_hold_stalled_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind idct8_stream idct8_stream_chk #(.BUS_W(BUS_W), .SMP_W(SMP_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_fire   (in_fire),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/idct8_stream_bench.sv
module idct8_stream_bench;

  localparam int BUS_W = 32;
  localparam int SMP_W = 16;
  localparam int NV    = 6;
  localparam int NSML  = 4;   // first NSML vectors are small-amplitude
  localparam real PI   = 3.14159265358979323846;

  // Stimulus table: one row per transform, X[0]..X[7].
  localparam shortint VEC [NV][8] = '{
    '{1000, 0, 0, 0, 0, 0, 0, 0},
    '{0, 1000, 0, 0, 0, 0, 0, 0},
    '{100, -200, 300, -400, 500, -600, 700, -800},
    '{-1024, 512, -256, 128, -64, 32, -16, 8},
    '{32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767},
    '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid;
  logic             in_ready;
  logic [BUS_W-1:0] in_data;
  logic             out_valid;
  logic             out_ready;
  logic [BUS_W-1:0] out_data;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  idct8_stream #(.BUS_W(BUS_W), .SMP_W(SMP_W)) u_idct8_stream (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  function automatic real amp(input int k);
    return (k == 0) ? 1.0 / $sqrt(2.0) : 1.0;
  endfunction

  function automatic int rnd_away(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  // Expected integer result, R3 and R4.
  function automatic int expect_int(input int v, input int n);
    longint s = 0;
    for (int k = 0; k < 8; k++) begin
      int c = rnd_away(8192.0 * amp(k) * $cos((2 * n + 1) * k * PI / 16.0));
      s += longint'(c) * longint'(VEC[v][k]);
    end
    s = (s + 64'sd8192) >>> 14;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  // Real-valued transform, R9.
  function automatic real expect_real(input int v, input int n);
    real s = 0.0;
    for (int k = 0; k < 8; k++)
      s += amp(k) / 2.0 * real'(VEC[v][k]) * $cos((2 * n + 1) * k * PI / 16.0);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [BUS_W-1:0] w, input int gap);
    repeat (gap) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    in_data = '0;
  endtask

  task automatic send_vec(input int v, input int gap);
    for (int k = 0; k < 8; k++)
      put({16'hA5C3 ^ 16'(k * 4097), 16'(VEC[v][k])}, gap);
  endtask

  task automatic get_one(input int v, input int n, input int stall);
    logic [BUS_W-1:0] held;
    int               got;
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    check(in_ready == 1'b0, "R2", "in_ready while emitting", in_ready, 0);
    held = out_data;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(out_valid == 1'b1 && out_data == held, "R7", "stalled word held",
            out_data, held);
    end
    out_ready = 1'b1;
    got = int'($signed(out_data[SMP_W-1:0]));
    check(got == expect_int(v, n), (v >= NSML) ? "R4" : "R3",
          $sformatf("vec %0d result %0d (R6 order)", v, n), got, expect_int(v, n));
    check(out_data[BUS_W-1:SMP_W] == {(BUS_W-SMP_W){out_data[SMP_W-1]}}, "R5",
          "sign extension", out_data[BUS_W-1:SMP_W], {(BUS_W-SMP_W){out_data[SMP_W-1]}});
    if (v < NSML) begin
      real d = real'(got) - expect_real(v, n);
      check(d <= 1.0 && d >= -1.0, "R9", $sformatf("vec %0d result %0d vs real", v, n),
            got, rnd_away(expect_real(v, n)));
    end
    @(posedge clk);
    #1 out_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst       = 1'b1;
    in_valid  = 1'b0;
    in_data   = '0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R8", "in_ready in reset", in_ready, 1);
    check(out_valid == 1'b0, "R8", "out_valid in reset", out_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0, "R8", "state after reset",
          {in_ready, out_valid}, 2);

    // Table walk: junk upper bits exercise R1, gaps and stalls vary timing.
    for (int v = 0; v < NV; v++) begin
      send_vec(v, v % 2);
      for (int n = 0; n < 8; n++) get_one(v, n, (n + v) % 3);
      @(negedge clk);
      check(out_valid == 1'b0, "R6", "no ninth result", out_valid, 0);
      check(in_ready == 1'b1, "R2", "input reopened", in_ready, 1);
    end

    // R2: after eight words, the next offered word is refused.
    send_vec(2, 0);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h0000_7FFF;
    check(in_ready == 1'b0, "R2", "ninth word refused", in_ready, 0);
    @(negedge clk);
    in_valid = 1'b0;
    for (int n = 0; n < 8; n++) get_one(2, n, 0);

    // R8: reset discards three gathered words.
    put(32'h0000_1234, 0);
    put(32'h0000_4321, 0);
    put(32'h0000_7FFF, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(in_ready == 1'b1 && out_valid == 1'b0, "R8", "mid-gather reset",
          {in_ready, out_valid}, 2);
    send_vec(0, 0);
    for (int n = 0; n < 8; n++) get_one(0, n, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule